// File: doc/BRIEF.md
# Time-of-day timer control register block

This block is the software-facing register file of a time-of-day timer subsystem. A host reaches it over a plain 32-bit bus with a valid, a write flag, a byte address and write data. Read data comes back one cycle later with its own valid flag. The block keeps the timer configuration, interrupt enables and latched interrupt status, and the software values for seconds and nanoseconds. It also keeps a signed seconds/nanoseconds offset, a write-only trim word and the 56-bit clock period of the timer.

Some locations act on a write instead of storing it. They produce single-cycle pulses that ask the timer to take a snapshot, to load the software time, or to load the offset. The two-word clock period is staged and reaches the timer only when its upper word is written, which also raises a commit strobe. Values captured from the timer are latched on a capture strobe and are read back as read-only words. Events on the two pulse-per-second sources set sticky status bits, and a single interrupt line reports any status bit that is enabled.

Top module: `timer_csr`

## Requirements
- R1: Reset (synchronous, active high) clears every read-write register, the status bits, the trigger pulses and the interrupt output to 0. It loads the clock period with the parameter PERIOD_RST, whose default is 56'h03_3333_3333_3333.
- R2: Write-one-to-trigger locations are 0x04 and 0x1C. Writing 1 to bit 0 of 0x04 gives snap_pulse. Writing 1 to bit 0 of 0x1C gives time_load_pulse, and writing 1 to bit 1 of 0x1C gives offs_load_pulse. Each pulse is high for exactly the one cycle after the write. A written 0 gives no pulse, and both locations read as 0.
- R3: The trim word at 0x34 is write-only. A write drives all 32 bits onto trim_value, and a read returns 0.
- R4: The status word at 0x0C is write-one-to-clear. Bit 0 is set by pps_int_evt and bit 16 by pps_ext_evt. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R5: The enable word at 0x08 uses the same bits 0 and 16. irq is high exactly when some status bit and its enable bit are both 1, from the cycle after the status bit is set.
- R6: The clock period is written as a low word at 0x2C and an upper word at 0x30, whose bits [23:0] are period bits [55:32]. A low-word write alone changes neither the period output nor its readback. An upper-word write updates the full period and raises period_commit for one cycle. Bits [31:24] of 0x30 read as 0.
- R7: The configuration word at 0x00 is read-write. Bit 0 is tmr_en, bit 1 is ext_bus_en, bits [3:2] are ovr_mode, bit 4 is auto_refresh and bit 5 is snap_on_pps. Bits [16+NPORTS-1:16] are port_en. All other bits read as 0.
- R8: The load time words are 0x10 (seconds [31:0]), 0x14 (seconds [47:32] in bits [15:0]) and 0x18 (nanoseconds in bits [29:0]). The offset words 0x20, 0x24 and 0x28 use the same layout. Each word drives its output field, and the bits above each field read as 0.
- R9: A cap_valid pulse latches cap_sec and cap_ns. They read back at 0x40 (seconds [31:0]), 0x44 (seconds [47:32]) and 0x48 (nanoseconds). Between pulses these words hold their value, and bus writes to them have no effect.
- R10: A read returns its data with rsp_valid high in the cycle after the request. Unmapped addresses return 0. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pps_int_evt | input | 1 | Internal seconds-rollover event pulse |
| pps_ext_evt | input | 1 | External pulse-per-second event pulse |
| cap_valid | input | 1 | Capture strobe for timer values |
| cap_sec | input | 48 | Captured seconds |
| cap_ns | input | 30 | Captured nanoseconds |
| tmr_en | output | 1 | Timer enable |
| ext_bus_en | output | 1 | External time bus enable |
| ovr_mode | output | 2 | Overwrite mode on external pulse |
| auto_refresh | output | 1 | Automatic refresh of port timers |
| snap_on_pps | output | 1 | Snapshot on external pulse |
| port_en | output | NPORTS | Per-port timer enables |
| snap_pulse | output | 1 | Snapshot trigger pulse |
| time_load_pulse | output | 1 | Software time load pulse |
| offs_load_pulse | output | 1 | Offset load pulse |
| load_sec | output | 48 | Software load seconds |
| load_ns | output | 30 | Software load nanoseconds |
| offs_sec | output | 48 | Signed seconds offset |
| offs_ns | output | 30 | Signed nanoseconds offset |
| period | output | 56 | Committed clock period |
| period_commit | output | 1 | Period commit strobe |
| trim_value | output | 32 | Write-only trim word |
| irq | output | 1 | Masked interrupt |

## Verification
Every stored value, trigger pulse, commit strobe and status update appears one clock edge after the request or event that causes it. Read data appears one edge after the read request. The bench drives all stimulus on the falling edge and samples at the next falling edge, which is exactly one rising edge later. It then checks at a second falling edge that each pulse has dropped again. A clear and an event that meet in the same cycle are driven together in a single cycle, so the priority between them is checked directly.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int SEC_W    = 48;
    localparam int NS_W     = 30;
    localparam int PER_W    = 56;
    localparam int SEC_HI_W = SEC_W - DATA_W;
    localparam int PER_HI_W = PER_W - DATA_W;

    // word addresses
    localparam logic [ADDR_W-1:0] A_CFG     = 8'h00;
    localparam logic [ADDR_W-1:0] A_SNAP    = 8'h04;
    localparam logic [ADDR_W-1:0] A_IEN     = 8'h08;
    localparam logic [ADDR_W-1:0] A_ISTAT   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_LSEC_LO = 8'h10;
    localparam logic [ADDR_W-1:0] A_LSEC_HI = 8'h14;
    localparam logic [ADDR_W-1:0] A_LNS     = 8'h18;
    localparam logic [ADDR_W-1:0] A_LOAD    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_OSEC_LO = 8'h20;
    localparam logic [ADDR_W-1:0] A_OSEC_HI = 8'h24;
    localparam logic [ADDR_W-1:0] A_ONS     = 8'h28;
    localparam logic [ADDR_W-1:0] A_PER_LO  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_PER_HI  = 8'h30;
    localparam logic [ADDR_W-1:0] A_TRIM    = 8'h34;
    localparam logic [ADDR_W-1:0] A_CSEC_LO = 8'h40;
    localparam logic [ADDR_W-1:0] A_CSEC_HI = 8'h44;
    localparam logic [ADDR_W-1:0] A_CNS     = 8'h48;

    localparam int TRIG_SNAP_BIT = 0;
    localparam int TRIG_TIME_BIT = 0;
    localparam int TRIG_OFFS_BIT = 1;

    localparam int IRQ_INT_BIT = 0;
    localparam int IRQ_EXT_BIT = 16;
    localparam logic [DATA_W-1:0] IRQ_MASK =
        (DATA_W'(1) << IRQ_INT_BIT) | (DATA_W'(1) << IRQ_EXT_BIT);

    localparam int CFG_PORT_LSB = 16;
    localparam logic [DATA_W-1:0] CFG_CTRL_MASK = 32'h0000_003F;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/tcr_irq.sv
module tcr_irq
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_int,
    input  logic              evt_ext,
    output logic [DATA_W-1:0] ien,
    output logic [DATA_W-1:0] istat,
    output logic              irq
);
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] clr_vec;

    always_comb begin
        evt_vec = '0;
        evt_vec[IRQ_INT_BIT] = evt_int;
        evt_vec[IRQ_EXT_BIT] = evt_ext;
        clr_vec = st_wr ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            istat <= '0;
        end else begin
            if (en_wr) ien <= wdata & IRQ_MASK;
            // a setting event outranks a clear in the same cycle
            istat <= ((istat & ~clr_vec) | evt_vec) & IRQ_MASK;
        end
    end

    assign irq = |(istat & ien);

    p_evt_wins_int_r4: assert property (@(posedge clk) disable iff (rst)
        $past(evt_int && !rst) |-> istat[IRQ_INT_BIT]);
    p_evt_wins_ext_r4: assert property (@(posedge clk) disable iff (rst)
        $past(evt_ext && !rst) |-> istat[IRQ_EXT_BIT]);
    p_zero_clear_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && st_wr && !wdata[IRQ_INT_BIT] && istat[IRQ_INT_BIT])
        |-> istat[IRQ_INT_BIT]);
endmodule

// File: rtl/tcr_period.sv
module tcr_period
    import tcr_pkg::*;
#(
    parameter logic [PER_W-1:0] PERIOD_RST = 56'h03_3333_3333_3333
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [PER_W-1:0]  period,
    output logic              commit
);
    logic [DATA_W-1:0] lo_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_stage <= PERIOD_RST[DATA_W-1:0];
            period   <= PERIOD_RST;
            commit   <= 1'b0;
        end else begin
            commit <= wr_hi;
            if (wr_lo) lo_stage <= wdata;
            if (wr_hi) period <= {wdata[PER_HI_W-1:0], lo_stage};
        end
    end

    p_period_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !commit && !$past(rst) |-> $stable(period));
endmodule

// File: rtl/tcr_capture.sv
module tcr_capture
    import tcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_valid,
    input  tod_t cap_in,
    output tod_t held
);
    always_ff @(posedge clk) begin
        if (rst)            held <= '0;
        else if (cap_valid) held <= cap_in;
    end

    p_cap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(cap_valid) && !$past(rst) |-> $stable(held));
endmodule

// File: rtl/tcr_rdmux.sv
module tcr_rdmux
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cfg,
    input  logic [DATA_W-1:0] ien,
    input  logic [DATA_W-1:0] istat,
    input  tod_t              load,
    input  tod_t              offs,
    input  logic [PER_W-1:0]  period,
    input  tod_t              cap,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (addr)
            A_CFG:     sel = cfg;
            A_IEN:     sel = ien;
            A_ISTAT:   sel = istat;
            A_LSEC_LO: sel = load.sec[DATA_W-1:0];
            A_LSEC_HI: sel = DATA_W'(load.sec[SEC_W-1:DATA_W]);
            A_LNS:     sel = DATA_W'(load.ns);
            A_OSEC_LO: sel = offs.sec[DATA_W-1:0];
            A_OSEC_HI: sel = DATA_W'(offs.sec[SEC_W-1:DATA_W]);
            A_ONS:     sel = DATA_W'(offs.ns);
            A_PER_LO:  sel = period[DATA_W-1:0];
            A_PER_HI:  sel = DATA_W'(period[PER_W-1:DATA_W]);
            A_CSEC_LO: sel = cap.sec[DATA_W-1:0];
            A_CSEC_HI: sel = DATA_W'(cap.sec[SEC_W-1:DATA_W]);
            A_CNS:     sel = DATA_W'(cap.ns);
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? sel : '0;
        end
    end

    p_trig_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && ($past(addr) == A_SNAP || $past(addr) == A_LOAD) |-> rsp_rdata == '0);
    p_wo_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(addr) == A_TRIM |-> rsp_rdata == '0);
endmodule

// File: rtl/timer_csr.sv
module timer_csr
    import tcr_pkg::*;
#(
    parameter int               NPORTS     = 4,
    parameter logic [PER_W-1:0] PERIOD_RST = 56'h03_3333_3333_3333
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              pps_int_evt,
    input  logic              pps_ext_evt,
    input  logic              cap_valid,
    input  logic [SEC_W-1:0]  cap_sec,
    input  logic [NS_W-1:0]   cap_ns,
    output logic              tmr_en,
    output logic              ext_bus_en,
    output logic [1:0]        ovr_mode,
    output logic              auto_refresh,
    output logic              snap_on_pps,
    output logic [NPORTS-1:0] port_en,
    output logic              snap_pulse,
    output logic              time_load_pulse,
    output logic              offs_load_pulse,
    output logic [SEC_W-1:0]  load_sec,
    output logic [NS_W-1:0]   load_ns,
    output logic [SEC_W-1:0]  offs_sec,
    output logic [NS_W-1:0]   offs_ns,
    output logic [PER_W-1:0]  period,
    output logic              period_commit,
    output logic [DATA_W-1:0] trim_value,
    output logic              irq
);
    localparam logic [DATA_W-1:0] PORT_MASK =
        ((DATA_W'(1) << NPORTS) - DATA_W'(1)) << CFG_PORT_LSB;
    localparam logic [DATA_W-1:0] CFG_MASK = PORT_MASK | CFG_CTRL_MASK;

    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] cfg_q, trim_q, ien, istat;
    tod_t              load_q, offs_q, cap_q, cap_in;
    logic              snap_q, tload_q, oload_q;

    assign wr_en = req_valid & req_write;
    assign rd_en = req_valid & ~req_write;
    assign wa    = word_addr(req_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            trim_q  <= '0;
            load_q  <= '0;
            offs_q  <= '0;
            snap_q  <= 1'b0;
            tload_q <= 1'b0;
            oload_q <= 1'b0;
        end else begin
            snap_q  <= wr_en && wa == A_SNAP && req_wdata[TRIG_SNAP_BIT];
            tload_q <= wr_en && wa == A_LOAD && req_wdata[TRIG_TIME_BIT];
            oload_q <= wr_en && wa == A_LOAD && req_wdata[TRIG_OFFS_BIT];
            if (wr_en) begin
                case (wa)
                    A_CFG:     cfg_q <= req_wdata & CFG_MASK;
                    A_LSEC_LO: load_q.sec[DATA_W-1:0]     <= req_wdata;
                    A_LSEC_HI: load_q.sec[SEC_W-1:DATA_W] <= req_wdata[SEC_HI_W-1:0];
                    A_LNS:     load_q.ns                  <= req_wdata[NS_W-1:0];
                    A_OSEC_LO: offs_q.sec[DATA_W-1:0]     <= req_wdata;
                    A_OSEC_HI: offs_q.sec[SEC_W-1:DATA_W] <= req_wdata[SEC_HI_W-1:0];
                    A_ONS:     offs_q.ns                  <= req_wdata[NS_W-1:0];
                    A_TRIM:    trim_q <= req_wdata;
                    default:   ;
                endcase
            end
        end
    end

    tcr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (wr_en && wa == A_IEN),
        .st_wr   (wr_en && wa == A_ISTAT),
        .wdata   (req_wdata),
        .evt_int (pps_int_evt),
        .evt_ext (pps_ext_evt),
        .ien     (ien),
        .istat   (istat),
        .irq     (irq)
    );

    tcr_period #(.PERIOD_RST(PERIOD_RST)) u_period (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (wr_en && wa == A_PER_LO),
        .wr_hi  (wr_en && wa == A_PER_HI),
        .wdata  (req_wdata),
        .period (period),
        .commit (period_commit)
    );

    assign cap_in.sec = cap_sec;
    assign cap_in.ns  = cap_ns;

    tcr_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .cap_in    (cap_in),
        .held      (cap_q)
    );

    tcr_rdmux u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .addr      (wa),
        .cfg       (cfg_q),
        .ien       (ien),
        .istat     (istat),
        .load      (load_q),
        .offs      (offs_q),
        .period    (period),
        .cap       (cap_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign tmr_en          = cfg_q[0];
    assign ext_bus_en      = cfg_q[1];
    assign ovr_mode        = cfg_q[3:2];
    assign auto_refresh    = cfg_q[4];
    assign snap_on_pps     = cfg_q[5];
    assign port_en         = cfg_q[CFG_PORT_LSB +: NPORTS];
    assign snap_pulse      = snap_q;
    assign time_load_pulse = tload_q;
    assign offs_load_pulse = oload_q;
    assign load_sec        = load_q.sec;
    assign load_ns         = load_q.ns;
    assign offs_sec        = offs_q.sec;
    assign offs_ns         = offs_q.ns;
    assign trim_value      = trim_q;

    p_snap_cause_r2: assert property (@(posedge clk) disable iff (rst)
        snap_pulse |-> $past(req_valid && req_write &&
                             word_addr(req_addr) == A_SNAP && req_wdata[TRIG_SNAP_BIT]));
    p_zero_no_load_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && req_valid && req_write && word_addr(req_addr) == A_LOAD &&
              !req_wdata[TRIG_TIME_BIT]) |-> !time_load_pulse);
    p_cfg_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(word_addr(req_addr)) == A_CFG |-> (rsp_rdata & ~CFG_MASK) == '0);
endmodule

// File: tb/test_timer_csr.sv
module test_timer_csr;
    import tcr_pkg::*;

    localparam int NP = 4;
    localparam logic [PER_W-1:0] PRST = 56'h03_3333_3333_3333;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst, req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rsp_rdata, trim_value;
    logic              rsp_valid, pps_int_evt, pps_ext_evt, cap_valid;
    logic [SEC_W-1:0]  cap_sec, load_sec, offs_sec;
    logic [NS_W-1:0]   cap_ns, load_ns, offs_ns;
    logic              tmr_en, ext_bus_en, auto_refresh, snap_on_pps;
    logic [1:0]        ovr_mode;
    logic [NP-1:0]     port_en;
    logic              snap_pulse, time_load_pulse, offs_load_pulse, period_commit, irq;
    logic [PER_W-1:0]  period;

    timer_csr #(.NPORTS(NP), .PERIOD_RST(PRST)) i_timer_csr (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pps_int_evt(pps_int_evt), .pps_ext_evt(pps_ext_evt),
        .cap_valid(cap_valid), .cap_sec(cap_sec), .cap_ns(cap_ns), .tmr_en(tmr_en),
        .ext_bus_en(ext_bus_en), .ovr_mode(ovr_mode), .auto_refresh(auto_refresh),
        .snap_on_pps(snap_on_pps), .port_en(port_en), .snap_pulse(snap_pulse),
        .time_load_pulse(time_load_pulse), .offs_load_pulse(offs_load_pulse),
        .load_sec(load_sec), .load_ns(load_ns), .offs_sec(offs_sec), .offs_ns(offs_ns),
        .period(period), .period_commit(period_commit), .trim_value(trim_value), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "rsp_valid", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
    endtask

    task automatic expect_read(input string req, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] exp);
        logic [DATA_W-1:0] d;
        bus_read(a, d);
        check(req, $sformatf("read 0x%02h", a), 64'(d), 64'(exp));
    endtask

    task automatic t_reset;
        check("R1", "period", 64'(period), 64'(PRST));
        check("R1", "irq", 64'(irq), 64'd0);
        check("R1", "tmr_en", 64'(tmr_en), 64'd0);
        check("R1", "pulses", 64'({snap_pulse, time_load_pulse, offs_load_pulse, period_commit}), 64'd0);
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        expect_read("R1", A_CFG, 32'h0);
        expect_read("R1", A_LSEC_LO, 32'h0);
        expect_read("R1", A_PER_LO, 32'h3333_3333);
        expect_read("R1", A_PER_HI, 32'h0003_3333);
    endtask

    task automatic t_config;
        bus_write(A_CFG, 32'hFFFF_FFFF);
        check("R7", "tmr_en", 64'(tmr_en), 64'd1);
        check("R7", "ovr_mode", 64'(ovr_mode), 64'd3);
        check("R7", "port_en", 64'(port_en), 64'hF);
        expect_read("R7", A_CFG, 32'h000F_003F);
        bus_write(A_CFG, 32'h0002_0009);
        check("R7", "fields", 64'({port_en, snap_on_pps, auto_refresh, ovr_mode, ext_bus_en, tmr_en}),
              64'({4'b0010, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1}));
        expect_read("R10", A_CFG | 8'h3, 32'h0002_0009);
    endtask

    task automatic t_triggers;
        bus_write(A_SNAP, 32'h1);
        check("R2", "snap high", 64'(snap_pulse), 64'd1);
        check("R2", "load low", 64'({time_load_pulse, offs_load_pulse}), 64'd0);
        @(negedge clk);
        check("R2", "snap one cycle", 64'(snap_pulse), 64'd0);
        bus_write(A_SNAP, 32'h0);
        check("R2", "snap on zero", 64'(snap_pulse), 64'd0);
        bus_write(A_LOAD, 32'h2);
        check("R2", "offs load", 64'({time_load_pulse, offs_load_pulse}), 64'b01);
        bus_write(A_LOAD, 32'h1);
        check("R2", "time load", 64'({time_load_pulse, offs_load_pulse}), 64'b10);
        @(negedge clk);
        check("R2", "load one cycle", 64'(time_load_pulse), 64'd0);
        bus_write(A_LOAD, 32'h0);
        check("R2", "load on zero", 64'({time_load_pulse, offs_load_pulse}), 64'd0);
        bus_write(A_LOAD, 32'h3);
        expect_read("R2", A_LOAD, 32'h0);
        expect_read("R2", A_SNAP, 32'h0);
    endtask

    task automatic t_wo;
        bus_write(A_TRIM, 32'hDEAD_BEEF);
        check("R3", "trim_value", 64'(trim_value), 64'hDEAD_BEEF);
        expect_read("R3", A_TRIM, 32'h0);
    endtask

    task automatic t_irq;
        bus_write(A_IEN, 32'hFFFF_FFFE);
        expect_read("R5", A_IEN, 32'h0001_0000);
        bus_write(A_IEN, 32'h0000_0001);
        @(negedge clk); pps_ext_evt = 1'b1;
        @(negedge clk); pps_ext_evt = 1'b0;
        check("R5", "irq masked", 64'(irq), 64'd0);
        expect_read("R4", A_ISTAT, 32'h0001_0000);
        @(negedge clk); pps_int_evt = 1'b1;
        @(negedge clk); pps_int_evt = 1'b0;
        check("R5", "irq raised", 64'(irq), 64'd1);
        bus_write(A_ISTAT, 32'h0);
        expect_read("R4", A_ISTAT, 32'h0001_0001);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_ISTAT; req_wdata = 32'h1;
        pps_int_evt = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; pps_int_evt = 1'b0;
        check("R4", "event beats clear", 64'(irq), 64'd1);
        bus_write(A_ISTAT, 32'h1);
        check("R5", "irq after clear", 64'(irq), 64'd0);
        expect_read("R4", A_ISTAT, 32'h0001_0000);
        bus_write(A_ISTAT, 32'h0001_0000);
        expect_read("R4", A_ISTAT, 32'h0);
    endtask

    task automatic t_period;
        bus_write(A_PER_LO, 32'h1234_5678);
        check("R6", "period after lo", 64'(period), 64'(PRST));
        check("R6", "no commit", 64'(period_commit), 64'd0);
        expect_read("R6", A_PER_LO, 32'h3333_3333);
        bus_write(A_PER_HI, 32'hAB9A_BCDE);
        check("R6", "commit", 64'(period_commit), 64'd1);
        check("R6", "period", 64'(period), 64'h009A_BCDE_1234_5678);
        @(negedge clk);
        check("R6", "commit one cycle", 64'(period_commit), 64'd0);
        expect_read("R6", A_PER_HI, 32'h009A_BCDE);
        expect_read("R6", A_PER_LO, 32'h1234_5678);
    endtask

    task automatic t_load_regs;
        bus_write(A_LSEC_LO, 32'hCAFE_F00D);
        bus_write(A_LSEC_HI, 32'hFFFF_ABCD);
        bus_write(A_LNS, 32'hFFFF_FFFF);
        check("R8", "load_sec", 64'(load_sec), 64'hABCD_CAFE_F00D);
        check("R8", "load_ns", 64'(load_ns), 64'h3FFF_FFFF);
        expect_read("R8", A_LSEC_HI, 32'h0000_ABCD);
        expect_read("R8", A_LNS, 32'h3FFF_FFFF);
        bus_write(A_OSEC_LO, 32'h0000_0005);
        bus_write(A_OSEC_HI, 32'h0001_8000);
        bus_write(A_ONS, 32'hC000_0007);
        check("R8", "offs_sec", 64'(offs_sec), 64'h8000_0000_0005);
        check("R8", "offs_ns", 64'(offs_ns), 64'h7);
        expect_read("R8", A_OSEC_HI, 32'h0000_8000);
        expect_read("R8", A_ONS, 32'h7);
    endtask

    task automatic t_capture;
        @(negedge clk);
        cap_sec = 48'h1234_89AB_CDEF; cap_ns = 30'h2AAA_AAAA; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0; cap_sec = 48'hFFFF_FFFF_FFFF; cap_ns = 30'h1;
        repeat (2) @(negedge clk);
        expect_read("R9", A_CSEC_LO, 32'h89AB_CDEF);
        expect_read("R9", A_CSEC_HI, 32'h0000_1234);
        expect_read("R9", A_CNS, 32'h2AAA_AAAA);
        bus_write(A_CSEC_LO, 32'h0);
        bus_write(A_CNS, 32'h0);
        expect_read("R9", A_CSEC_LO, 32'h89AB_CDEF);
        expect_read("R9", A_CNS, 32'h2AAA_AAAA);
    endtask

    task automatic t_unmapped;
        expect_read("R10", 8'h3C, 32'h0);
        expect_read("R10", 8'hFC, 32'h0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        pps_int_evt = 1'b0; pps_ext_evt = 1'b0; cap_valid = 1'b0; cap_sec = '0; cap_ns = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_config();
        t_triggers();
        t_wo();
        t_irq();
        t_period();
        t_load_regs();
        t_capture();
        t_unmapped();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end
endmodule